// File: doc/BRIEF.md
# Endpoint Token Admission Controller

This block decides, for every token the serial engine receives, whether the addressed endpoint pair takes part in the transaction and what reply goes back to the host. It keeps one small control word per bidirectional endpoint pair. Each control word holds five fields:

- an IN enable;
- an OUT enable;
- a bit that turns off control (SETUP) traffic;
- a handshake enable, which is cleared for isochronous traffic;
- a sticky stall flag.

Firmware writes and reads the control words through a plain register port. The engine raises the stall flag of a pair when it stalls that pair. The flag then stays set until firmware writes it back to zero or the block is reset.

A token is presented for one cycle together with its kind and endpoint number. One cycle later the block reports the outcome:

- **Accept or reject.** A rejected token is ignored and gets no reply.
- **Handshake or STALL.** For an accepted token, the block says whether to send a handshake or a STALL.

Endpoint 0 is the default control endpoint, so SETUP can never be turned off for it.

Top module: `ep_admit`

## Requirements
- R1: After reset every control word reads 0, so every endpoint pair is disabled, and `dec_valid` stays low until a token is presented.
- R2: Control word bit positions are: bit 0 stall, bit 1 handshake enable, bit 2 OUT enable, bit 3 IN enable, bit 4 control disable. A write through `cfg_we` takes effect at the next clock edge. `cfg_rdata` shows the word selected by `cfg_addr` in the same cycle.
- R3: Bit 4 of endpoint 0 always reads 0, whatever is written. A SETUP token to endpoint 0 therefore needs only its IN and OUT enables.
- R4: An OUT token (`tok_kind` = 0) is accepted exactly when the addressed OUT enable is set.
- R5: An IN token (`tok_kind` = 1) is accepted exactly when the addressed IN enable is set.
- R6: A SETUP token (`tok_kind` = 2) is accepted exactly when the control disable is clear and both the IN and OUT enables are set.
- R7: A token that is not accepted, including the reserved kind 3, gives `dec_reject` = 1 with `dec_accept`, `dec_handshake` and `dec_stall` all 0.
- R8: When the handshake enable is clear, an accepted token gives neither a handshake nor a STALL, even with the stall flag set.
- R9: When the stall flag and the handshake enable are both set, an accepted IN or OUT token gives `dec_stall` = 1 and `dec_handshake` = 0. An accepted SETUP token still gives a handshake.
- R10: A `stall_set` pulse sets the stall flag of `stall_ep` at the next edge. The flag stays set through idle cycles and through tokens until firmware writes bit 0 as 0, or until reset.
- R11: If a firmware write and a `stall_set` hit the same endpoint in the same cycle, the stall flag ends up set. The other fields take the written values.
- R12: Every token gives exactly one decision, one cycle later, with exactly one of `dec_accept` and `dec_reject` set. Back-to-back tokens give back-to-back decisions. When `dec_valid` is low, all decision flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Firmware write strobe |
| cfg_addr | input | 3 | Endpoint pair selected for write and read |
| cfg_wdata | input | 5 | Control word to write |
| cfg_rdata | output | 5 | Control word of the selected pair |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 reserved |
| tok_ep | input | 3 | Endpoint number of the token |
| stall_set | input | 1 | Engine stalled an endpoint this cycle |
| stall_ep | input | 3 | Endpoint whose stall flag is set |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Token admitted |
| dec_reject | output | 1 | Token ignored, no reply |
| dec_handshake | output | 1 | Send a handshake |
| dec_stall | output | 1 | Send a STALL |

## Verification
Each token kind is sent against control words that differ in a single enable bit. A wrong enable term in the admission rule therefore shows up as a flipped accept. SETUP is tried with the control disable set and cleared, both on endpoint 0 and on another pair. This separates the forced endpoint-0 behaviour from the general rule. Stalled pairs are probed with all three token kinds, both with and without the handshake enable, which tells apart the STALL, handshake and silent outcomes. A firmware write that lands in the same cycle as a stall set exposes the wrong priority between the two.

// File: rtl/ep_admit_pkg.sv
package ep_admit_pkg;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_kind_e;

  // Packed MSB first: bit4 ctl_off, bit3 in_en, bit2 out_en, bit1 hs_en, bit0 stall
  typedef struct packed {
    logic ctl_off;
    logic in_en;
    logic out_en;
    logic hs_en;
    logic stall;
  } ep_cfg_t;

  localparam int CFG_W = $bits(ep_cfg_t);

  typedef struct packed {
    logic accept;
    logic reject;
    logic handshake;
    logic stall;
  } ep_verdict_t;

endpackage

// File: rtl/ep_admit_entry.sv
module ep_admit_entry
  import ep_admit_pkg::*;
#(
  parameter bit KEEP_SETUP = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fw_we,
  input  ep_cfg_t fw_data,
  input  logic    hw_stall,
  output ep_cfg_t cfg_q
);

  ep_cfg_t cfg_d;
  logic    cfg_en;

  always_comb begin
    cfg_d = cfg_q;
    if (fw_we) begin
      cfg_d = fw_data;
    end
    if (KEEP_SETUP) begin
      cfg_d.ctl_off = 1'b0;
    end
    // engine set outranks a firmware clear
    if (hw_stall) begin
      cfg_d.stall = 1'b1;
    end
  end

  assign cfg_en = fw_we | hw_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assert_hw_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stall |=> cfg_q.stall);

  assert_stall_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.stall && !fw_we) |=> cfg_q.stall);

  assert_fw_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_we && !hw_stall) |=> (cfg_q.in_en == $past(fw_data.in_en)) &&
                             (cfg_q.out_en == $past(fw_data.out_en)) &&
                             (cfg_q.stall == $past(fw_data.stall)));

endmodule

// File: rtl/ep_admit_regbank.sv
module ep_admit_regbank
  import ep_admit_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [EP_W-1:0] wr_sel,
  input  ep_cfg_t         wr_data,
  input  logic [EP_W-1:0] rd_sel,
  output ep_cfg_t         rd_data,
  input  logic            hw_stall,
  input  logic [EP_W-1:0] hw_sel,
  input  logic [EP_W-1:0] tok_sel,
  output ep_cfg_t         tok_cfg
);

  ep_cfg_t cfg_arr [NUM_EP];

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic we_hit;
    logic set_hit;
    assign we_hit  = wr_en & (wr_sel == EP_W'(g));
    assign set_hit = hw_stall & (hw_sel == EP_W'(g));

    ep_admit_entry #(
      .KEEP_SETUP(g == 0)
    ) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .fw_we   (we_hit),
      .fw_data (wr_data),
      .hw_stall(set_hit),
      .cfg_q   (cfg_arr[g])
    );
  end

  assign rd_data = cfg_arr[rd_sel];
  assign tok_cfg = cfg_arr[tok_sel];

  assert_ep0_setup_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == '0) |=> !cfg_arr[0].ctl_off);

endmodule

// File: rtl/ep_admit_decide.sv
module ep_admit_decide
  import ep_admit_pkg::*;
(
  input  tok_kind_e   kind,
  input  ep_cfg_t     cfg,
  output ep_verdict_t verdict
);

  logic ok;
  logic stall_rsp;

  always_comb begin
    unique case (kind)
      TOK_OUT:   ok = cfg.out_en;
      TOK_IN:    ok = cfg.in_en;
      TOK_SETUP: ok = !cfg.ctl_off && cfg.in_en && cfg.out_en;
      default:   ok = 1'b0;
    endcase
    stall_rsp         = ok && cfg.hs_en && cfg.stall && (kind != TOK_SETUP);
    verdict.accept    = ok;
    verdict.reject    = !ok;
    verdict.stall     = stall_rsp;
    verdict.handshake = ok && cfg.hs_en && !stall_rsp;
  end

  always_comb begin
    assert_reply_exclusive_R9: assert (!(verdict.handshake && verdict.stall));
  end

endmodule

// File: rtl/ep_admit.sv
module ep_admit
  import ep_admit_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [EP_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic [EP_W-1:0]  tok_ep,
  input  logic             stall_set,
  input  logic [EP_W-1:0]  stall_ep,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_reject,
  output logic             dec_handshake,
  output logic             dec_stall
);

  logic        rst_meta;
  logic        rst_q;
  ep_cfg_t     rd_cfg;
  ep_cfg_t     tok_cfg;
  ep_verdict_t verdict;
  ep_verdict_t verdict_d;
  ep_verdict_t verdict_q;
  logic        valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  ep_admit_regbank #(
    .NUM_EP(NUM_EP)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_addr),
    .wr_data (ep_cfg_t'(cfg_wdata)),
    .rd_sel  (cfg_addr),
    .rd_data (rd_cfg),
    .hw_stall(stall_set),
    .hw_sel  (stall_ep),
    .tok_sel (tok_ep),
    .tok_cfg (tok_cfg)
  );

  ep_admit_decide u_decide (
    .kind   (tok_kind_e'(tok_kind)),
    .cfg    (tok_cfg),
    .verdict(verdict)
  );

  always_comb begin
    verdict_d = tok_valid ? verdict : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      valid_q   <= tok_valid;
      verdict_q <= verdict_d;
    end
  end

  assign cfg_rdata     = rd_cfg;
  assign dec_valid     = valid_q;
  assign dec_accept    = verdict_q.accept;
  assign dec_reject    = verdict_q.reject;
  assign dec_handshake = verdict_q.handshake;
  assign dec_stall     = verdict_q.stall;

  assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_q)
    dec_valid |-> $onehot({dec_accept, dec_reject}));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_q)
    !dec_valid |-> !(dec_accept || dec_reject || dec_handshake || dec_stall));

  assert_token_latency_R12: assert property (@(posedge clk) disable iff (!rst_q)
    tok_valid |=> dec_valid);

  assert_reject_silent_R7: assert property (@(posedge clk) disable iff (!rst_q)
    dec_reject |-> !(dec_handshake || dec_stall));

  assert_reply_needs_accept_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (dec_handshake || dec_stall) |-> dec_accept);

endmodule

// File: tb/ep_admit_tb.sv
`timescale 1ns/1ps
module ep_admit_tb;

  localparam int NEP = 8;
  localparam realtime TCLK = 4.0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [4:0] cfg_wdata;
  logic [4:0] cfg_rdata;
  logic       tok_valid;
  logic [1:0] tok_kind;
  logic [2:0] tok_ep;
  logic       stall_set;
  logic [2:0] stall_ep;
  logic       dec_valid, dec_accept, dec_reject, dec_handshake, dec_stall;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [4:0]  model [NEP];
  logic [3:0]  exp_q [$];
  string       tag_q [$];

  always #(TCLK/2) clk = ~clk;

  ep_admit #(.NUM_EP(NEP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ep(tok_ep),
    .stall_set(stall_set), .stall_ep(stall_ep),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reject(dec_reject),
    .dec_handshake(dec_handshake), .dec_stall(dec_stall)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {accept,reject,handshake,stall}; bit0 stall,1 hs,2 out,3 in,4 ctl_off
  function automatic logic [3:0] expect_of(input logic [1:0] kind, input logic [4:0] w);
    logic ok, st;
    case (kind)
      2'd0: ok = w[2];
      2'd1: ok = w[3];
      2'd2: ok = !w[4] && w[3] && w[2];
      default: ok = 1'b0;
    endcase
    st = ok && w[1] && w[0] && (kind != 2'd2);
    return {ok, !ok, ok && w[1] && !st, st};
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0;
    model = '{default: 5'd0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input int ep, input logic [4:0] d, input bit hw, input int hep);
    cfg_we = 1'b1; cfg_addr = 3'(ep); cfg_wdata = d;
    stall_set = hw; stall_ep = 3'(hep);
    @(negedge clk);
    cfg_we = 1'b0; stall_set = 1'b0;
    model[ep] = d;
    if (ep == 0) model[0][4] = 1'b0;
    if (hw) model[hep][0] = 1'b1;
  endtask

  task automatic hw_stall(input int ep);
    stall_set = 1'b1; stall_ep = 3'(ep);
    @(negedge clk);
    stall_set = 1'b0;
    model[ep][0] = 1'b1;
  endtask

  task automatic rd_check(input int ep, input string req);
    cfg_addr = 3'(ep);
    #0.5;
    check(cfg_rdata === model[ep], req, 8'(cfg_rdata), 8'(model[ep]));
  endtask

  task automatic tok(input logic [1:0] kind, input int ep, input string req);
    exp_q.push_back(expect_of(kind, model[ep]));
    tag_q.push_back(req);
    tok_valid = 1'b1; tok_kind = kind; tok_ep = 3'(ep);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  // monitor: decisions are compared in arrival order
  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected decision", 8'd1, 8'd0);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({dec_accept, dec_reject, dec_handshake, dec_stall} === e, t,
              8'({dec_accept, dec_reject, dec_handshake, dec_stall}), 8'(e));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(TCLK * 100000);
    check(1'b0, "watchdog", 8'd0, 8'd1);
    finish_run();
  end

  initial begin
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    tok_valid = 0; tok_kind = 0; tok_ep = 0;
    stall_set = 0; stall_ep = 0;
    apply_reset();

    // R1: all zero after reset, no decisions
    for (int i = 0; i < NEP; i++) rd_check(i, "R1 reset value");
    check(dec_valid === 1'b0, "R1 idle after reset", 8'(dec_valid), 8'd0);
    tok(2'd0, 3, "R1 R7 disabled endpoint OUT");
    tok(2'd2, 0, "R1 R7 disabled ep0 SETUP");

    // R2 R4 R5 R6: OUT only with handshake
    wr(2, 5'b00110, 0, 0);
    rd_check(2, "R2 readback ep2");
    tok(2'd0, 2, "R4 OUT accepted");
    tok(2'd1, 2, "R5 IN rejected");
    tok(2'd2, 2, "R6 SETUP needs IN");

    // R8 R5: IN only, no handshake
    wr(3, 5'b01000, 0, 0);
    tok(2'd1, 3, "R5 R8 IN silent accept");
    tok(2'd0, 3, "R4 OUT rejected");

    // R6: control disabled on ep4
    wr(4, 5'b11110, 0, 0);
    rd_check(4, "R2 readback ep4");
    tok(2'd2, 4, "R6 SETUP blocked by ctl_off");
    tok(2'd0, 4, "R4 OUT on ep4");

    // R3: endpoint 0 keeps SETUP
    wr(0, 5'b11110, 0, 0);
    rd_check(0, "R3 ep0 ctl_off forced");
    tok(2'd2, 0, "R3 SETUP on ep0");

    // R9 R10: stall on ep5
    wr(5, 5'b01110, 0, 0);
    tok(2'd2, 5, "R6 SETUP accepted ep5");
    hw_stall(5);
    rd_check(5, "R10 stall set");
    tok(2'd1, 5, "R9 IN stalled");
    tok(2'd0, 5, "R9 OUT stalled");
    tok(2'd2, 5, "R9 SETUP handshake while stalled");
    repeat (5) @(negedge clk);
    rd_check(5, "R10 stall sticky");
    wr(5, 5'b01110, 0, 0);
    rd_check(5, "R10 firmware clear");
    tok(2'd1, 5, "R10 IN handshake after clear");

    // R11: write clears stall while engine sets it
    wr(5, 5'b01010, 1, 5);
    rd_check(5, "R11 hardware set wins");
    tok(2'd0, 5, "R11 R4 OUT disabled by write");
    tok(2'd1, 5, "R11 IN stalled");
    wr(6, 5'b01111, 1, 7);
    rd_check(6, "R2 ep6 written");
    rd_check(7, "R10 ep7 stall set");
    tok(2'd1, 7, "R7 ep7 stall only, rejected");

    // R8: stall without handshake
    hw_stall(3);
    tok(2'd1, 3, "R8 stalled no handshake");

    // R7 R12: reserved kind, back to back
    tok(2'd3, 6, "R7 reserved kind");
    tok(2'd1, 6, "R12 back to back 1");
    tok(2'd0, 6, "R12 back to back 2");
    tok(2'd1, 2, "R12 back to back 3");
    @(negedge clk);
    check(dec_valid === 1'b0, "R12 idle after burst", 8'(dec_valid), 8'd0);
    check(exp_q.size() == 0, "R12 all decisions seen", 8'(exp_q.size()), 8'd0);

    // R1 R10: reset clears stall
    apply_reset();
    for (int i = 0; i < NEP; i++) rd_check(i, "R1 R10 cleared by reset");
    tok(2'd1, 5, "R1 disabled after reset");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R12 queue drained", 8'(exp_q.size()), 8'd0);
    finish_run();
  end

endmodule